// File: doc/BRIEF.md
# Port Change Interrupt Logic

This block raises the interrupt of a 16-pin general-purpose I/O expander that is arranged as two byte-wide ports. For each port it holds a captured copy of the input levels as they stood at the last read of that port. It compares the live, synchronized pin levels against that copy. Any difference on a pin whose direction bit marks it as an input pulls the interrupt line active.

Reading a port returns the synchronized byte and refreshes only that port's copy. The interrupt therefore clears when the host reads the port that changed, or when the changed pins go back to their captured levels. The interrupt pin is open-drain. It is modelled as a drive value that is always low plus an output enable, and the enable is the active interrupt.

The pin inputs pass through a synchronizer chain before any comparison. After reset the captured copy is primed from the synchronized levels, so the line stays released.

Top module: `port_change_irq`

## Requirements
- R1: A level change on a pin whose direction bit is 1 (input) sets `irq_oe_o` high once the change has crossed the two synchronizer flops. The change is applied to `pin_i` before posedge k, `irq_oe_o` is still low after posedge k, and it is high after posedge k+1.
- R2: If a changed input pin returns to its captured level before any read of its port, `irq_oe_o` goes low again with the same two-edge latency.
- R3: A pin whose direction bit is 0 (output) never affects `irq_oe_o`, whatever its level.
- R4: A high `rd_stb_i[p]` at a clock edge loads byte p of `rd_data_o` and byte p of the captured copy with the level that the synchronized pins take at that same edge. After that edge port p contributes nothing to the interrupt. Port 0 is bits 7:0 and port 1 is bits 15:8.
- R5: A read of one port leaves a pending change on the other port untouched, so `irq_oe_o` stays high until the other port is also read.
- R6: `irq_pad_o` is low at all times, so the line is only ever pulled low or released.
- R7: When a direction bit changes from 0 to 1 while the synchronized level of that pin differs from its captured value, `irq_oe_o` rises in the same cycle, with no register in the path.
- R8: During reset and after its release, with static pins, `irq_oe_o` stays low and `rd_data_o` reads 0 until the first read strobe. A later read returns the pin levels that were present through reset, and it raises no interrupt.
- R9: If a pin change reaches the synchronized level at the same edge at which its port is read, the captured value takes the new level. `irq_oe_o` stays low.
- R10: `irq_oe_o` is the OR over all 16 pins of the input-enabled mismatch. It stays high while at least one input pin still differs from its captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 16 | Raw pin levels, not yet synchronized |
| dir_in_i | input | 16 | Per-pin direction, 1 = input, 0 = output |
| rd_stb_i | input | 2 | Per-port read strobe, bit p reads port p |
| rd_data_o | output | 16 | Registered read data, byte p updated by a read of port p |
| irq_oe_o | output | 1 | Interrupt output enable, high while the interrupt is active |
| irq_pad_o | output | 1 | Drive value of the open-drain interrupt pin, always 0 |

## Verification
A captured byte that is wrong shows up at `irq_oe_o` as soon as it differs from the live input levels. It also shows up at `rd_data_o` after the next read, because the read data and the captured byte are loaded from the same source at the same edge. A read that clears the wrong port, or a synchronizer of the wrong depth, becomes visible within one or two cycles. It appears as an interrupt that stays active or goes inactive against the expected latency. Direction masking errors show only when an output pin toggles or a direction bit flips. Those cases are driven explicitly, and the bench samples the same cycle for the combinational direction path.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  localparam int unsigned PORT_W  = 8;
  localparam int unsigned N_PORTS = 2;
  localparam int unsigned PIN_W   = PORT_W * N_PORTS;

  // Per-pin change term: differs from capture and enabled as an input.
  function automatic logic [PORT_W-1:0] pin_mismatch(
    input logic [PORT_W-1:0] live,
    input logic [PORT_W-1:0] held,
    input logic [PORT_W-1:0] is_in
  );
    return (live ^ held) & is_in;
  endfunction
endpackage

// File: rtl/pcx_sync.sv
module pcx_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] pre_o,  // level the output takes at the next edge
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign pre_o = chain_q[STAGES-2];
  assign q_o   = chain_q[STAGES-1];
endmodule

// File: rtl/pcx_port_snap.sv
module pcx_port_snap
  import pcx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prime_i,
  input  logic              rd_i,
  input  logic [PORT_W-1:0] pre_i,
  input  logic [PORT_W-1:0] live_i,
  input  logic [PORT_W-1:0] is_in_i,
  output logic [PORT_W-1:0] held_o,
  output logic [PORT_W-1:0] rd_byte_o,
  output logic              pend_o
);
  logic [PORT_W-1:0] held_q;
  logic [PORT_W-1:0] rd_q;

  // Capture the level the synchronizer presents after this edge, so a
  // change landing together with a read is absorbed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else if (prime_i || rd_i) held_q <= pre_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else if (rd_i) rd_q <= pre_i;
  end

  assign held_o    = held_q;
  assign rd_byte_o = rd_q;
  assign pend_o    = |pin_mismatch(live_i, held_q, is_in_i);
endmodule

// File: rtl/port_change_irq.sv
module port_change_irq
  import pcx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PIN_W-1:0]    pin_i,
  input  logic [PIN_W-1:0]    dir_in_i,
  input  logic [N_PORTS-1:0]  rd_stb_i,
  output logic [PIN_W-1:0]    rd_data_o,
  output logic                irq_oe_o,
  output logic                irq_pad_o
);
  localparam int unsigned PRIME_W = $clog2(SYNC_STAGES + 1);

  logic [PIN_W-1:0]   sync_pre;
  logic [PIN_W-1:0]   sync_lvl;
  logic [PIN_W-1:0]   held_lvl;
  logic [N_PORTS-1:0] port_pend;
  logic [PRIME_W-1:0] prime_q;
  logic               priming;

  pcx_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .pre_o (sync_pre),
    .q_o   (sync_lvl)
  );

  // Capture follows the chain until it holds real pin levels.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prime_q <= PRIME_W'(SYNC_STAGES);
    else if (priming) prime_q <= prime_q - 1'b1;
  end
  assign priming = (prime_q != '0);

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    pcx_port_snap u_snap (
      .clk       (clk),
      .rst_n     (rst_n),
      .prime_i   (priming),
      .rd_i      (rd_stb_i[p]),
      .pre_i     (sync_pre[p*PORT_W +: PORT_W]),
      .live_i    (sync_lvl[p*PORT_W +: PORT_W]),
      .is_in_i   (dir_in_i[p*PORT_W +: PORT_W]),
      .held_o    (held_lvl[p*PORT_W +: PORT_W]),
      .rd_byte_o (rd_data_o[p*PORT_W +: PORT_W]),
      .pend_o    (port_pend[p])
    );
  end

  assign irq_oe_o  = |port_pend;
  assign irq_pad_o = 1'b0;
endmodule

// File: rtl/port_change_irq_chk.sv
module port_change_irq_chk
  import pcx_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [PIN_W-1:0]   dir_in_i,
  input logic [N_PORTS-1:0] rd_stb_i,
  input logic [PIN_W-1:0]   rd_data_o,
  input logic               irq_oe_o,
  input logic [PIN_W-1:0]   sync_lvl,
  input logic [PIN_W-1:0]   held_lvl,
  input logic [N_PORTS-1:0] port_pend,
  input logic               priming
);
  AST_OUTPUT_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_in_i == '0) |-> !irq_oe_o); // R3

  AST_IRQ_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe_o == (|port_pend)); // R10

  AST_PRIME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    priming |-> (!irq_oe_o && held_lvl == sync_lvl)); // R8

  for (genvar p = 0; p < N_PORTS; p++) begin : g_chk
    AST_READ_CLEARS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb_i[p] |=> !port_pend[p]); // R4

    AST_READ_DATA_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb_i[p] |=> (rd_data_o[p*PORT_W +: PORT_W] == sync_lvl[p*PORT_W +: PORT_W])); // R9

    AST_OTHER_PORT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i == N_PORTS'(1 << p)) |=> $stable(held_lvl[((p+1)%N_PORTS)*PORT_W +: PORT_W])); // R5
  end
endmodule

bind port_change_irq port_change_irq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dir_in_i  (dir_in_i),
  .rd_stb_i  (rd_stb_i),
  .rd_data_o (rd_data_o),
  .irq_oe_o  (irq_oe_o),
  .sync_lvl  (sync_lvl),
  .held_lvl  (held_lvl),
  .port_pend (port_pend),
  .priming   (priming)
);

// File: tb/port_change_irq_tb.sv
`timescale 1ns/1ps
module port_change_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin = '0;
  logic [15:0] dir = '0;
  logic [1:0]  rd  = '0;
  logic [15:0] rd_data;
  logic        irq_oe;
  logic        irq_pad;

  int n_chk = 0;
  int n_bad = 0;
  bit over  = 1'b0;

  always #4 clk = ~clk;

  port_change_irq dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pin),
    .dir_in_i  (dir),
    .rd_stb_i  (rd),
    .rd_data_o (rd_data),
    .irq_oe_o  (irq_oe),
    .irq_pad_o (irq_pad)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!over) begin
      over = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // Own restatement of the interrupt: any input pin off its captured value.
  function automatic logic exp_irq(input logic [15:0] lvl, input logic [15:0] cap,
                                   input logic [15:0] inp);
    logic r = 1'b0;
    for (int i = 0; i < 16; i++) if (inp[i] && (lvl[i] != cap[i])) r = 1'b1;
    return r;
  endfunction

  task automatic settle(); repeat (2) @(negedge clk); endtask

  task automatic do_read(input logic [1:0] which);
    rd = which;
    @(negedge clk);
    rd = '0;
  endtask

  task automatic t_reset();
    pin = 16'hA5C3; dir = 16'hFFFF; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 oe during reset", irq_oe, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 oe after reset", irq_oe, 1'b0);
    check("R8 rd_data reset", rd_data, 16'h0000);
    do_read(2'b11);
    check("R8 read after reset", rd_data, 16'hA5C3);
    check("R8 no irq after read", irq_oe, 1'b0);
    check("R6 pad low", irq_pad, 1'b0);
  endtask

  task automatic t_change_return();
    pin[4] = ~pin[4];
    @(negedge clk);
    check("R1 not yet after one edge", irq_oe, 1'b0);
    @(negedge clk);
    check("R1 raised after two edges", irq_oe, exp_irq(pin, 16'hA5C3, dir));
    check("R6 pad low while active", irq_pad, 1'b0);
    pin[4] = ~pin[4];
    @(negedge clk);
    check("R2 still active one edge", irq_oe, 1'b1);
    @(negedge clk);
    check("R2 released on return", irq_oe, 1'b0);
  endtask

  task automatic t_output_dir();
    dir = 16'h00FF;
    pin[12] = ~pin[12];
    settle();
    check("R3 output pin ignored", irq_oe, 1'b0);
    dir = 16'hFFFF;
    #1;
    check("R7 dir switch raises same cycle", irq_oe, 1'b1);
    @(negedge clk);
    pin[12] = ~pin[12];
    settle();
    check("R7 released after restore", irq_oe, 1'b0);
  endtask

  task automatic t_read_clear();
    pin[3] = ~pin[3];
    settle();
    check("R4 pending before read", irq_oe, 1'b1);
    do_read(2'b01);
    check("R4 read clears", irq_oe, 1'b0);
    check("R4 read data port0", rd_data[7:0], pin[7:0]);
  endtask

  task automatic t_independent();
    pin[2] = ~pin[2]; pin[9] = ~pin[9];
    settle();
    check("R5 both pending", irq_oe, 1'b1);
    do_read(2'b01);
    check("R5 port1 still pending", irq_oe, 1'b1);
    check("R5 port0 read data", rd_data[7:0], pin[7:0]);
    do_read(2'b10);
    check("R5 port1 read clears", irq_oe, 1'b0);
    check("R5 port1 read data", rd_data[15:8], pin[15:8]);
  endtask

  task automatic t_same_cycle();
    pin[14] = ~pin[14];
    @(negedge clk);        // change is one stage in
    rd = 2'b10;
    @(negedge clk);        // sync and capture update at the same edge
    rd = '0;
    check("R9 no irq on coincident read", irq_oe, 1'b0);
    check("R9 capture took new level", rd_data[15:8], pin[15:8]);
    @(negedge clk);
    check("R9 still quiet", irq_oe, 1'b0);
  endtask

  task automatic t_multi();
    pin[1] = ~pin[1]; pin[6] = ~pin[6];
    settle();
    check("R10 two pins pending", irq_oe, 1'b1);
    pin[1] = ~pin[1];
    settle();
    check("R10 one pin still off", irq_oe, 1'b1);
    pin[6] = ~pin[6];
    settle();
    check("R10 all restored", irq_oe, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_change_return();
    t_output_dir();
    t_read_clear();
    t_independent();
    t_same_cycle();
    t_multi();
    check("R6 pad low at end", irq_pad, 1'b0);
    summary();
  end
endmodule